// File: doc/BRIEF.md
# Guarded Interrupt Vector Placement Register

This block holds the control byte that decides where the processor fetches interrupt vectors from. Vectors are taken either from word address zero of program memory or from the first word of the boot section. Where the boot section starts depends on a two-bit size code. The placement bit is protected. Software must first set an arming bit. It then has a short, fixed number of clock cycles in which one more write may load the placement bit. A stray write therefore cannot move the vector table.

While the arming bit is set, the block drives an interrupt-hold output that tells the interrupt controller to defer delivery. After a placement write is accepted, the hold stays on until the core reports that the next instruction has completed. The hold is a separate signal, so the core's global interrupt-enable flag is never modified.

The same hold output also applies the two lock inputs to the current execution region. One lock blocks interrupts from application code when vectors live in the boot section. The other lock blocks interrupts from boot code when vectors live in the application area. The register also holds a pull-up disable bit that is not protected.

Top module: `ivec_reloc_ctrl`

## Requirements
- R1: A synchronous reset clears the register. Afterwards `reg_rdata` reads 0x00 and `vec_base` is 0. With both lock inputs low, `irq_suppress` is 0.
- R2: Register bit layout: bit 4 is pull-up disable, bit 1 is vector placement, bit 0 is the arming bit, and every other bit reads 0. A write (`reg_sel` and `reg_we` both high) always loads bit 4, with or without an open window.
- R3: A write with bit 0 = 1 sets the arming bit. From the next cycle, bit 0 reads 1 and `irq_suppress` is high.
- R4: If no placement write arrives, the arming bit stays set for exactly 4 cycles and then clears by itself. `irq_suppress` drops in the same cycle.
- R5: A write with bit 0 = 0 during any of those 4 cycles loads the placement bit from bit 1 and clears the arming bit. The new placement is visible in the next cycle.
- R6: The placement bit does not change on a write with bit 0 = 0 made while the arming bit is clear, or on any write with bit 0 = 1. A write with bit 0 = 1 made while armed restarts the 4-cycle window.
- R7: After a placement write is accepted, `irq_suppress` stays high until `insn_done` is sampled high. It drops in the following cycle.
- R8: `vec_base` is 0 while placement is 0. While placement is 1, it is the boot start word address selected by `boot_size`. The defaults are 0x1F80, 0x1F00, 0x1E00 and 0x1C00 for codes 0, 1, 2 and 3.
- R9: `irq_suppress` is high in two cases. The first is placement 1, `lock_app_run` high and `exec_in_boot` low. The second is placement 0, `lock_boot_run` high and `exec_in_boot` high. The other lock, region and placement combinations do not raise it.
- R10: A write strobe without `reg_sel` has no effect on the register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_sel | input | 1 | Register address match |
| reg_we | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data byte |
| boot_size | input | 2 | Boot section size code |
| exec_in_boot | input | 1 | 1 while the core executes from the boot section |
| lock_app_run | input | 1 | Lock: block interrupts in application code when vectors are in boot |
| lock_boot_run | input | 1 | Lock: block interrupts in boot code when vectors are in application |
| insn_done | input | 1 | Pulse from the core when an instruction completes |
| reg_rdata | output | 8 | Register read value |
| vec_base | output | ADDR_W | Vector table base word address |
| irq_suppress | output | 1 | Hold interrupt delivery |

## Verification
The unlock sequence is driven with placement writes in several positions:
- inside the last window cycle, to prove the window is four cycles wide;
- one cycle after it, to prove the window is not five cycles wide;
- with no window open;
- after re-arming.

Comparing these cases separates a window that is one cycle off from a correct one, and a re-arm that restarts the window from one that only holds it. The suppress window is run both with and without a commit and with `insn_done` delayed, which tells the timed end apart from the end triggered by the instruction. The lock gating is driven through all four combinations of placement and region for each lock, so a swapped or missing term shows up. Each boot size code is also read back with placement in the boot section.

// File: rtl/ivr_pkg.sv
package ivr_pkg;

    localparam int REG_W    = 8;
    localparam int BIT_ARM  = 0;
    localparam int BIT_SEL  = 1;
    localparam int BIT_PUD  = 4;

    typedef enum logic {
        RGN_APP  = 1'b0,
        RGN_BOOT = 1'b1
    } exec_region_e;

    typedef struct packed {
        logic valid;
        logic pud;
        logic sel;
        logic arm;
    } wr_req_t;

    typedef struct packed {
        logic pud;
        logic sel;
        logic arm;
    } ctl_bits_t;

    function automatic wr_req_t decode_write(input logic hit, input logic [REG_W-1:0] d);
        wr_req_t r;
        r.valid = hit;
        r.pud   = d[BIT_PUD];
        r.sel   = d[BIT_SEL];
        r.arm   = d[BIT_ARM];
        return r;
    endfunction

    function automatic logic [REG_W-1:0] pack_readback(input ctl_bits_t c);
        logic [REG_W-1:0] r;
        r          = '0;
        r[BIT_PUD] = c.pud;
        r[BIT_SEL] = c.sel;
        r[BIT_ARM] = c.arm;
        return r;
    endfunction

endpackage

// File: rtl/ivr_unlock.sv
module ivr_unlock
    import ivr_pkg::*;
#(
    parameter int WIN = 4
) (
    input  logic      clk,
    input  logic      rst,
    input  wr_req_t   req,
    input  logic      insn_done,
    output ctl_bits_t bits_o,
    output logic      hold_o
);

    localparam int CW = $clog2(WIN + 1);

    logic          arm_q;
    logic          sel_q;
    logic          pud_q;
    logic          tail_q;
    logic [CW-1:0] cnt_q;

    logic do_arm;
    logic do_commit;

    assign do_arm    = req.valid & req.arm;
    assign do_commit = req.valid & ~req.arm & arm_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pud_q <= 1'b0;
        end else if (req.valid) begin
            pud_q <= req.pud;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            arm_q <= 1'b0;
            cnt_q <= '0;
            sel_q <= 1'b0;
        end else if (do_arm) begin
            arm_q <= 1'b1;
            cnt_q <= CW'(WIN);
        end else if (do_commit) begin
            arm_q <= 1'b0;
            cnt_q <= '0;
            sel_q <= req.sel;
        end else if (arm_q) begin
            if (cnt_q == CW'(1)) begin
                arm_q <= 1'b0;
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tail_q <= 1'b0;
        end else if (do_commit) begin
            tail_q <= 1'b1;
        end else if (insn_done) begin
            tail_q <= 1'b0;
        end
    end

    assign bits_o = '{pud: pud_q, sel: sel_q, arm: arm_q};
    assign hold_o = arm_q | tail_q;

    AST_ARM_FROM_WRITE: assert property (@(posedge clk) disable iff (rst)
        $rose(arm_q) |-> $past(req.valid & req.arm)); // R3

    AST_WINDOW_CLOSES: assert property (@(posedge clk) disable iff (rst)
        (arm_q && cnt_q == CW'(1) && !req.valid) |=> !arm_q); // R4

    AST_SEL_GUARDED: assert property (@(posedge clk) disable iff (rst)
        !(arm_q && req.valid && !req.arm) |=> $stable(sel_q)); // R6

    AST_COMMIT_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (arm_q && req.valid && !req.arm) |=> (hold_o && !arm_q)); // R7

    AST_TAIL_ENDS: assert property (@(posedge clk) disable iff (rst)
        (tail_q && !arm_q && insn_done && !req.valid) |=> !hold_o); // R7

endmodule

// File: rtl/ivr_base_mux.sv
module ivr_base_mux #(
    parameter int              ADDR_W  = 13,
    parameter logic [ADDR_W-1:0] START_0 = 13'h1F80,
    parameter logic [ADDR_W-1:0] START_1 = 13'h1F00,
    parameter logic [ADDR_W-1:0] START_2 = 13'h1E00,
    parameter logic [ADDR_W-1:0] START_3 = 13'h1C00
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sel,
    input  logic [1:0]        size_code,
    output logic [ADDR_W-1:0] base_o
);

    localparam int NSIZES = 4;

    logic [ADDR_W-1:0] start_tab [NSIZES];

    generate
        for (genvar i = 0; i < NSIZES; i++) begin : g_tab
            if (i == 0) begin : g0
                assign start_tab[i] = START_0;
            end else if (i == 1) begin : g1
                assign start_tab[i] = START_1;
            end else if (i == 2) begin : g2
                assign start_tab[i] = START_2;
            end else begin : g3
                assign start_tab[i] = START_3;
            end
        end
    endgenerate

    always_comb begin
        base_o = '0;
        if (sel) begin
            base_o = start_tab[size_code];
        end
    end

    AST_APP_BASE_ZERO: assert property (@(posedge clk) disable iff (rst)
        !sel |-> (base_o == '0)); // R8

endmodule

// File: rtl/ivr_lock_gate.sv
module ivr_lock_gate
    import ivr_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         sel,
    input  exec_region_e region,
    input  logic         lock_app_run,
    input  logic         lock_boot_run,
    output logic         block_o
);

    logic blk_app;
    logic blk_boot;

    assign blk_app  = sel  & lock_app_run  & (region == RGN_APP);
    assign blk_boot = !sel & lock_boot_run & (region == RGN_BOOT);
    assign block_o  = blk_app | blk_boot;

    AST_LOCK_APP: assert property (@(posedge clk) disable iff (rst)
        (sel && lock_app_run && region == RGN_APP) |-> block_o); // R9

    AST_LOCK_NONE: assert property (@(posedge clk) disable iff (rst)
        (!lock_app_run && !lock_boot_run) |-> !block_o); // R9

endmodule

// File: rtl/ivec_reloc_ctrl.sv
module ivec_reloc_ctrl
    import ivr_pkg::*;
#(
    parameter int                ADDR_W     = 13,
    parameter int                WIN_CYCLES = 4,
    parameter logic [ADDR_W-1:0] BOOT_ST_0  = 13'h1F80,
    parameter logic [ADDR_W-1:0] BOOT_ST_1  = 13'h1F00,
    parameter logic [ADDR_W-1:0] BOOT_ST_2  = 13'h1E00,
    parameter logic [ADDR_W-1:0] BOOT_ST_3  = 13'h1C00
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_sel,
    input  logic              reg_we,
    input  logic [7:0]        reg_wdata,
    input  logic [1:0]        boot_size,
    input  logic              exec_in_boot,
    input  logic              lock_app_run,
    input  logic              lock_boot_run,
    input  logic              insn_done,
    output logic [7:0]        reg_rdata,
    output logic [ADDR_W-1:0] vec_base,
    output logic              irq_suppress
);

    wr_req_t      req;
    ctl_bits_t    bits;
    logic         unlock_hold;
    logic         lock_block;
    exec_region_e region;
    logic         unused_wdata;

    assign req          = decode_write(reg_sel & reg_we, reg_wdata);
    assign region       = exec_region_e'(exec_in_boot);
    assign unused_wdata = ^{reg_wdata[7:5], reg_wdata[3:2]};

    ivr_unlock #(
        .WIN (WIN_CYCLES)
    ) u_unlock (
        .clk       (clk),
        .rst       (rst),
        .req       (req),
        .insn_done (insn_done),
        .bits_o    (bits),
        .hold_o    (unlock_hold)
    );

    ivr_base_mux #(
        .ADDR_W  (ADDR_W),
        .START_0 (BOOT_ST_0),
        .START_1 (BOOT_ST_1),
        .START_2 (BOOT_ST_2),
        .START_3 (BOOT_ST_3)
    ) u_base (
        .clk       (clk),
        .rst       (rst),
        .sel       (bits.sel),
        .size_code (boot_size),
        .base_o    (vec_base)
    );

    ivr_lock_gate u_lock (
        .clk           (clk),
        .rst           (rst),
        .sel           (bits.sel),
        .region        (region),
        .lock_app_run  (lock_app_run),
        .lock_boot_run (lock_boot_run),
        .block_o       (lock_block)
    );

    assign reg_rdata    = pack_readback(bits);
    assign irq_suppress = unlock_hold | lock_block;

    AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (rst)
        (reg_rdata & 8'hEC) == 8'h00); // R2

    AST_NOSEL_NO_EFFECT: assert property (@(posedge clk) disable iff (rst)
        (!reg_sel && !bits.arm) |=> $stable(reg_rdata)); // R10

    AST_ARM_HOLDS: assert property (@(posedge clk) disable iff (rst)
        bits.arm |-> irq_suppress); // R3

endmodule

// File: tb/tb_ivec_reloc_ctrl.sv
`timescale 1ns/1ps
module tb_ivec_reloc_ctrl;

    localparam int AW = 13;

    logic          clk = 1'b0;
    logic          rst;
    logic          reg_sel, reg_we, insn_done;
    logic [7:0]    reg_wdata;
    logic [1:0]    boot_size;
    logic          exec_in_boot, lock_app_run, lock_boot_run;
    logic [7:0]    reg_rdata;
    logic [AW-1:0] vec_base;
    logic          irq_suppress;

    always #4 clk = ~clk;

    ivec_reloc_ctrl dut (
        .clk(clk), .rst(rst), .reg_sel(reg_sel), .reg_we(reg_we),
        .reg_wdata(reg_wdata), .boot_size(boot_size),
        .exec_in_boot(exec_in_boot), .lock_app_run(lock_app_run),
        .lock_boot_run(lock_boot_run), .insn_done(insn_done),
        .reg_rdata(reg_rdata), .vec_base(vec_base), .irq_suppress(irq_suppress)
    );

    typedef struct {
        string         tag;
        logic [7:0]    rdata;
        logic [AW-1:0] base;
        logic          sup;
    } exp_t;

    exp_t sb_q[$];
    int   n_chk  = 0;
    int   n_fail = 0;
    bit   done   = 0;

    // expectation state, kept from the requirement text
    bit       m_pud, m_sel, m_arm, m_tail;
    int       m_cnt;

    function automatic logic [AW-1:0] boot_start(input logic [1:0] c);
        case (c)
            2'd0:    return 13'h1F80;
            2'd1:    return 13'h1F00;
            2'd2:    return 13'h1E00;
            default: return 13'h1C00;
        endcase
    endfunction

    task automatic chk(input string tag, input string what, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %0h expected %0h", tag, what, got, exp);
        end
    endtask

    // driver: apply one cycle of stimulus and push what the outputs must show in it
    task automatic step(input bit r, input bit s, input bit w, input logic [7:0] d,
                        input bit insn, input string tag);
        exp_t e;
        bit   wr;
        rst = r; reg_sel = s; reg_we = w; reg_wdata = d; insn_done = insn;
        e.tag   = tag;
        e.rdata = {3'b0, m_pud, 2'b0, m_sel, m_arm};
        e.base  = m_sel ? boot_start(boot_size) : '0;
        e.sup   = m_arm | m_tail | (m_sel & lock_app_run & !exec_in_boot)
                | (!m_sel & lock_boot_run & exec_in_boot);
        sb_q.push_back(e);
        wr = s & w;
        if (r) begin
            m_pud = 0; m_sel = 0; m_arm = 0; m_tail = 0; m_cnt = 0;
        end else begin
            if (wr) m_pud = d[4];
            if (wr && d[0]) begin
                m_arm = 1; m_cnt = 4;
            end else if (wr && m_arm) begin
                m_sel = d[1]; m_arm = 0; m_tail = 1;
            end else if (m_arm) begin
                if (m_cnt == 1) m_arm = 0;
                else m_cnt--;
            end
            if (!(wr && !d[0] && e.rdata[0]) && insn) m_tail = 0;
        end
        @(negedge clk);
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) step(0, 0, 0, 8'h00, 0, tag);
    endtask

    // monitor: compares the outputs shortly before each rising edge
    always @(negedge clk) begin
        #3;
        if (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            chk(e.tag, "rdata", 32'(reg_rdata), 32'(e.rdata));
            chk(e.tag, "base",  32'(vec_base),  32'(e.base));
            chk(e.tag, "suppress", 32'(irq_suppress), 32'(e.sup));
        end
    end

    initial begin
        rst = 1; reg_sel = 0; reg_we = 0; reg_wdata = 0; insn_done = 0;
        boot_size = 0; exec_in_boot = 0; lock_app_run = 0; lock_boot_run = 0;
        m_pud = 0; m_sel = 0; m_arm = 0; m_tail = 0; m_cnt = 0;
        repeat (3) @(negedge clk);

        idle(1, "R1");
        step(0, 1, 1, 8'h10, 0, "R2");          // pull-up disable bit
        idle(1, "R2");
        step(0, 1, 1, 8'h12, 0, "R6");          // placement write, no window
        idle(1, "R6");
        step(0, 0, 1, 8'h03, 0, "R10");         // strobe without address match
        idle(1, "R10");

        step(0, 1, 1, 8'h01, 0, "R3");          // arm, let the window lapse
        idle(4, "R4");
        idle(2, "R4");

        step(0, 1, 1, 8'h01, 0, "R3");          // arm, commit in last window cycle
        idle(3, "R5");
        step(0, 1, 1, 8'h02, 0, "R5");
        idle(2, "R7");
        step(0, 0, 0, 8'h00, 1, "R7");          // instruction completes
        idle(2, "R7");

        for (int c = 0; c < 4; c++) begin
            boot_size = 2'(c);
            idle(1, "R8");
        end
        boot_size = 2'd3;

        step(0, 1, 1, 8'h01, 0, "R3");          // late write is ignored
        idle(4, "R6");
        step(0, 1, 1, 8'h00, 0, "R6");
        idle(2, "R6");

        step(0, 1, 1, 8'h01, 0, "R6");          // re-arm restarts the window
        idle(2, "R6");
        step(0, 1, 1, 8'h01, 0, "R6");
        idle(3, "R6");
        step(0, 1, 1, 8'h00, 0, "R5");
        step(0, 0, 0, 8'h00, 1, "R7");
        idle(2, "R8");

        // placement 0: walk both locks over both regions
        for (int k = 0; k < 8; k++) begin
            lock_app_run  = k[0];
            lock_boot_run = k[1];
            exec_in_boot  = k[2];
            idle(1, "R9");
        end
        lock_app_run = 0; lock_boot_run = 0; exec_in_boot = 0;
        step(0, 1, 1, 8'h01, 0, "R3");
        step(0, 1, 1, 8'h02, 0, "R5");
        step(0, 0, 0, 8'h00, 1, "R7");
        idle(1, "R7");
        for (int k = 0; k < 8; k++) begin
            lock_app_run  = k[0];
            lock_boot_run = k[1];
            exec_in_boot  = k[2];
            idle(1, "R9");
        end
        lock_app_run = 0; lock_boot_run = 0; exec_in_boot = 0;

        step(0, 1, 1, 8'h11, 0, "R3");          // reset in the middle of a window
        step(1, 0, 0, 8'h00, 0, "R1");
        idle(2, "R1");

        @(negedge clk);
        @(negedge clk);
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule